// File: doc/BRIEF.md
# Dual-Bank Pin Controller

This block drives and observes 32 general-purpose pins from a 32-bit register bus. Each line has a direction bit. Lines configured as inputs are sampled every clock. The sampled value can raise an event on a rising edge, a falling edge, a high level or a low level, and each of these four detectors is enabled per line. Every event sets the line's bit in two status registers, one per interrupt bank. Each bank combines its status with its own enable register to drive a separate interrupt output. This lets two different consumers, for example two processors, each pick the lines they care about.

Edge events can also raise a single-cycle wakeup request. This happens only when the idle configuration allows it and the line is enabled for wakeup. Alias addresses set or clear selected bits of the enable, wakeup-enable and output registers in one write, so no read-modify-write is needed. The bus accepts byte, halfword and word writes. A soft-reset bit in the configuration register returns the block to its reset values.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset, register reads return the following values. Revision (0x00) returns the REVISION parameter, default 0x18. The reset-done word (0x14) returns 1. Secondary config (0x30) returns 2. Direction (0x34) returns all ones. Config (0x10), status 0x18/0x28, enables 0x1C/0x2C, wakeup enable 0x20, detect registers 0x40 (low), 0x44 (high), 0x48 (rise) and 0x4C (fall), and the spare words 0x50/0x54 all return 0. A read request returns its data, with a valid flag, one cycle later.
- R2: A line whose direction bit is 1 (input) sets its bit in both status registers (0x18 and 0x28) when it rises with its rise bit set, or falls with its fall bit set. A line whose direction bit is 0 never sets status.
- R3: An input line that is high with its high-detect bit set, or low with its low-detect bit set, keeps its status bit set. Writing 1 to that bit does not clear it while the level holds. The write clears it once the level is gone.
- R4: Bit b of irq_o is high exactly when status bank b ANDed with enable bank b (0x1C for bank 0, 0x2C for bank 1) is nonzero. The two banks are independent.
- R5: Writing to an alias address acts only on the bits written as 1, as follows. 0x60 clears and 0x64 sets bank-0 enable bits. 0x70 and 0x74 do the same for bank 1. 0x80 and 0x84 do the same for wakeup enable. 0x90 and 0x94 do the same for output data (0x3C). A read of an alias address returns the underlying register.
- R6: wake_o pulses for one cycle, in the cycle after a qualifying edge event. An edge event qualifies only when config bit 2 is 1, config bits [4:3] are not 00, and the line's wakeup-enable bit is 1.
- R7: A config write with bit 1 set returns all registers to their R1 values, except output data. Config then keeps the written value ANDed with 0x1D. Secondary config keeps only its low 3 bits.
- R8: bus_size_i selects the access width: 0 for a byte, 1 for a halfword, 2 for a word. The lanes start at byte offset addr[1:0]. A narrow write to an ordinary register keeps the unaddressed bytes. A narrow write to a status or alias address applies only the shifted write data. A read returns the word shifted right by 8 times the byte offset.
- R9: pad_oe_o is the inverse of direction, and pad_out_o is the output data register. Input data (0x38) reads the sampled pins. Writes to 0x00, 0x14 and 0x38 have no effect.
- R10: Status bits never clear except through a write-1-to-clear or a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_size_i | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wdata_i | input | 32 | Write data, right-aligned |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| pad_in_i | input | 32 | Pin levels |
| pad_out_o | output | 32 | Pin drive values |
| pad_oe_o | output | 32 | Pin drive enables |
| irq_o | output | 2 | Interrupt per bank |
| wake_o | output | 1 | Wakeup request pulse |

## Verification
The hardest situation to reach is a status clear that collides with a level that is still present. In that case the clear must lose, and the bit must stay set until the pin itself moves. The stimulus holds a pin high with high detection enabled, issues the write-1-to-clear, and reads the status back. It then drops the pin and clears again, to show that the bit does go away. The wakeup pulse is just as narrow. The bench arranges the config and wakeup-enable values first, moves the pin in a known cycle, and samples wake_o in exactly the following cycle and the one after it.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NBANK = 2;
    localparam int CFGW = 8;

    localparam logic [AW-1:0] A_REV     = 8'h00;
    localparam logic [AW-1:0] A_CFG     = 8'h10;
    localparam logic [AW-1:0] A_RSTDONE = 8'h14;
    localparam logic [AW-1:0] A_ST0     = 8'h18;
    localparam logic [AW-1:0] A_EN0     = 8'h1C;
    localparam logic [AW-1:0] A_WKEN    = 8'h20;
    localparam logic [AW-1:0] A_ST1     = 8'h28;
    localparam logic [AW-1:0] A_EN1     = 8'h2C;
    localparam logic [AW-1:0] A_CFG2    = 8'h30;
    localparam logic [AW-1:0] A_DIR     = 8'h34;
    localparam logic [AW-1:0] A_DIN     = 8'h38;
    localparam logic [AW-1:0] A_DOUT    = 8'h3C;
    localparam logic [AW-1:0] A_LODET   = 8'h40;
    localparam logic [AW-1:0] A_HIDET   = 8'h44;
    localparam logic [AW-1:0] A_RISEDET = 8'h48;
    localparam logic [AW-1:0] A_FALLDET = 8'h4C;
    localparam logic [AW-1:0] A_SPARE0  = 8'h50;
    localparam logic [AW-1:0] A_SPARE1  = 8'h54;
    localparam logic [AW-1:0] A_EN0_CLR = 8'h60;
    localparam logic [AW-1:0] A_EN0_SET = 8'h64;
    localparam logic [AW-1:0] A_EN1_CLR = 8'h70;
    localparam logic [AW-1:0] A_EN1_SET = 8'h74;
    localparam logic [AW-1:0] A_WK_CLR  = 8'h80;
    localparam logic [AW-1:0] A_WK_SET  = 8'h84;
    localparam logic [AW-1:0] A_OUT_CLR = 8'h90;
    localparam logic [AW-1:0] A_OUT_SET = 8'h94;

    localparam logic [CFGW-1:0] CFG_KEEP  = 8'h1D;
    localparam int              CFG_SRST  = 1;
    localparam int              CFG_WKON  = 2;
    localparam logic [CFGW-1:0] CFG2_RST  = 8'h02;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
    } detect_cfg_t;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] word;
        logic [DW-1:0] mask;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
        logic [DW-1:0] base;
        case (acc_size_e'(sz))
            SZ_BYTE: base = 32'h0000_00FF;
            SZ_HALF: base = 32'h0000_FFFF;
            default: base = 32'hFFFF_FFFF;
        endcase
        return base << {off, 3'b000};
    endfunction

    function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] cur, input wr_req_t req);
        return (cur & ~req.mask) | req.data;
    endfunction
endpackage

// File: rtl/pinbank_busif.sv
module pinbank_busif
    import pinbank_pkg::*;
(
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [1:0]    bus_size_i,
    input  logic [DW-1:0] bus_wdata_i,
    output wr_req_t       req_o
);
    logic [DW-1:0] mask;

    always_comb begin
        mask        = lane_mask(bus_size_i, bus_addr_i[1:0]);
        req_o.wr    = bus_wr_i;
        req_o.word  = {bus_addr_i[AW-1:2], 2'b00};
        req_o.mask  = mask;
        req_o.data  = (bus_wdata_i << {bus_addr_i[1:0], 3'b000}) & mask;
    end
endmodule

// File: rtl/pinbank_events.sv
module pinbank_events
    import pinbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] pad_in_i,
    input  logic [DW-1:0] dir_i,
    input  detect_cfg_t   det_i,
    output logic [DW-1:0] in_q_o,
    output logic [DW-1:0] edge_hit_o,
    output logic [DW-1:0] level_hit_o
);
    logic [DW-1:0] rise, fall;

    always_ff @(posedge clk) begin
        if (rst) in_q_o <= '0;
        else     in_q_o <= pad_in_i;
    end

    always_comb begin
        rise        = pad_in_i & ~in_q_o & det_i.rise;
        fall        = ~pad_in_i & in_q_o & det_i.fall;
        edge_hit_o  = dir_i & (rise | fall);
        level_hit_o = dir_i & ((in_q_o & det_i.hi) | (~in_q_o & det_i.lo));
    end
endmodule

// File: rtl/pinbank_banks.sv
module pinbank_banks
    import pinbank_pkg::*;
#(
    parameter int NB = NBANK
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst_i,
    input  logic [DW-1:0]        edge_hit_i,
    input  logic [DW-1:0]        level_hit_i,
    input  logic [NB-1:0][DW-1:0] clr_i,
    input  logic [NB-1:0][DW-1:0] en_i,
    output logic [NB-1:0][DW-1:0] status_o,
    output logic [NB-1:0]        irq_o
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [DW-1:0] nxt;
        always_comb nxt = (status_o[b] & ~clr_i[b]) | edge_hit_i | level_hit_i;

        always_ff @(posedge clk) begin
            if (rst || soft_rst_i) status_o[b] <= '0;
            else                   status_o[b] <= nxt;
        end

        assign irq_o[b] = |(status_o[b] & en_i[b]);

        // R10: status bits survive any cycle without a clear or soft reset
        assert_status_sticky_R10: assert property (@(posedge clk) disable iff (rst)
            (clr_i[b] == '0 && !soft_rst_i) |=> ((status_o[b] & $past(status_o[b])) == $past(status_o[b])));
    end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  req_i,
    input  logic [AW-1:0]            rd_addr_i,
    input  logic [NBANK-1:0][DW-1:0] status_i,
    input  logic [DW-1:0]            in_q_i,
    output logic [DW-1:0]            rd_word_o,
    output logic                     soft_rst_o,
    output logic [CFGW-1:0]          cfg_o,
    output logic [DW-1:0]            dir_o,
    output logic [DW-1:0]            dout_o,
    output logic [DW-1:0]            wken_o,
    output logic [NBANK-1:0][DW-1:0] en_o,
    output logic [NBANK-1:0][DW-1:0] clr_o,
    output detect_cfg_t              det_o
);
    logic [CFGW-1:0] cfg2;
    logic [DW-1:0]   spare0, spare1;
    logic [DW-1:0]   cur_w, merged;

    function automatic logic [DW-1:0] reg_view(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        case ({a[AW-1:2], 2'b00})
            A_REV:                         v = {{(DW-8){1'b0}}, REVISION};
            A_CFG:                         v = {{(DW-CFGW){1'b0}}, cfg_o};
            A_RSTDONE:                     v = 32'd1;
            A_ST0:                         v = status_i[0];
            A_ST1:                         v = status_i[1];
            A_EN0, A_EN0_CLR, A_EN0_SET:   v = en_o[0];
            A_EN1, A_EN1_CLR, A_EN1_SET:   v = en_o[1];
            A_WKEN, A_WK_CLR, A_WK_SET:    v = wken_o;
            A_CFG2:                        v = {{(DW-CFGW){1'b0}}, cfg2};
            A_DIR:                         v = dir_o;
            A_DIN:                         v = in_q_i;
            A_DOUT, A_OUT_CLR, A_OUT_SET:  v = dout_o;
            A_LODET:                       v = det_o.lo;
            A_HIDET:                       v = det_o.hi;
            A_RISEDET:                     v = det_o.rise;
            A_FALLDET:                     v = det_o.fall;
            A_SPARE0:                      v = spare0;
            A_SPARE1:                      v = spare1;
            default:                       v = '0;
        endcase
        return v;
    endfunction

    always_comb begin
        rd_word_o  = reg_view(rd_addr_i);
        cur_w      = reg_view(req_i.word);
        merged     = merge_lanes(cur_w, req_i);
        soft_rst_o = req_i.wr && (req_i.word == A_CFG) && merged[CFG_SRST];
        clr_o[0]   = (req_i.wr && req_i.word == A_ST0) ? req_i.data : '0;
        clr_o[1]   = (req_i.wr && req_i.word == A_ST1) ? req_i.data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_o <= '0;
        else if (req_i.wr && req_i.word == A_CFG) cfg_o <= merged[CFGW-1:0] & CFG_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) dout_o <= '0;
        else if (req_i.wr) begin
            case (req_i.word)
                A_DOUT:    dout_o <= merged;
                A_OUT_CLR: dout_o <= dout_o & ~req_i.data;
                A_OUT_SET: dout_o <= dout_o | req_i.data;
                default:   dout_o <= dout_o;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst_o) begin
            cfg2   <= CFG2_RST;
            dir_o  <= '1;
            det_o  <= '0;
            en_o   <= '0;
            wken_o <= '0;
            spare0 <= '0;
            spare1 <= '0;
        end else if (req_i.wr) begin
            case (req_i.word)
                A_CFG2:    cfg2      <= {5'b0, merged[2:0]};
                A_DIR:     dir_o     <= merged;
                A_LODET:   det_o.lo  <= merged;
                A_HIDET:   det_o.hi  <= merged;
                A_RISEDET: det_o.rise <= merged;
                A_FALLDET: det_o.fall <= merged;
                A_EN0:     en_o[0]   <= merged;
                A_EN1:     en_o[1]   <= merged;
                A_WKEN:    wken_o    <= merged;
                A_EN0_CLR: en_o[0]   <= en_o[0] & ~req_i.data;
                A_EN0_SET: en_o[0]   <= en_o[0] | req_i.data;
                A_EN1_CLR: en_o[1]   <= en_o[1] & ~req_i.data;
                A_EN1_SET: en_o[1]   <= en_o[1] | req_i.data;
                A_WK_CLR:  wken_o    <= wken_o & ~req_i.data;
                A_WK_SET:  wken_o    <= wken_o | req_i.data;
                A_SPARE0:  spare0    <= merged;
                A_SPARE1:  spare1    <= merged;
                default:   ;
            endcase
        end
    end

    // R7: soft reset leaves secondary config at its reset value and direction all inputs
    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |=> (cfg2 == CFG2_RST && dir_o == '1 && en_o == '0));
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic [1:0]        bus_size_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              bus_rvalid_o,
    input  logic [DW-1:0]     pad_in_i,
    output logic [DW-1:0]     pad_out_o,
    output logic [DW-1:0]     pad_oe_o,
    output logic [NBANK-1:0]  irq_o,
    output logic              wake_o
);
    wr_req_t                  req;
    logic [DW-1:0]            rd_word, in_q, edge_hit, level_hit;
    logic [DW-1:0]            dir, dout, wken;
    logic [CFGW-1:0]          cfg;
    logic                     soft_rst;
    logic [NBANK-1:0][DW-1:0] status, en, clr;
    detect_cfg_t              det;
    logic                     wake_ok;

    pinbank_busif u_busif (
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .bus_size_i (bus_size_i),
        .bus_wdata_i(bus_wdata_i),
        .req_o      (req)
    );

    pinbank_regs #(.REVISION(REVISION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .rd_addr_i (bus_addr_i),
        .status_i  (status),
        .in_q_i    (in_q),
        .rd_word_o (rd_word),
        .soft_rst_o(soft_rst),
        .cfg_o     (cfg),
        .dir_o     (dir),
        .dout_o    (dout),
        .wken_o    (wken),
        .en_o      (en),
        .clr_o     (clr),
        .det_o     (det)
    );

    pinbank_events u_events (
        .clk        (clk),
        .rst        (rst),
        .pad_in_i   (pad_in_i),
        .dir_i      (dir),
        .det_i      (det),
        .in_q_o     (in_q),
        .edge_hit_o (edge_hit),
        .level_hit_o(level_hit)
    );

    pinbank_banks #(.NB(NBANK)) u_banks (
        .clk        (clk),
        .rst        (rst),
        .soft_rst_i (soft_rst),
        .edge_hit_i (edge_hit),
        .level_hit_i(level_hit),
        .clr_i      (clr),
        .en_i       (en),
        .status_o   (status),
        .irq_o      (irq_o)
    );

    assign pad_out_o = dout;
    assign pad_oe_o  = ~dir;
    assign wake_ok   = cfg[CFG_WKON] && (cfg[4:3] != 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid_o <= 1'b0;
            bus_rdata_o  <= '0;
            wake_o       <= 1'b0;
        end else begin
            bus_rvalid_o <= bus_rd_i;
            if (bus_rd_i) bus_rdata_o <= rd_word >> {bus_addr_i[1:0], 3'b000};
            wake_o <= !soft_rst && wake_ok && |(edge_hit & wken);
        end
    end

    // R1: every read request yields valid data on the next cycle
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
        bus_rd_i |=> bus_rvalid_o);

    // R2: a detected edge lands in both status banks
    assert_edge_to_status_R2: assert property (@(posedge clk) disable iff (rst)
        ((|edge_hit) && !soft_rst) |=> (((status[0] & status[1]) & $past(edge_hit)) == $past(edge_hit)));

    // R6: a wakeup pulse requires the wake gate in the preceding cycle
    assert_wake_gate_R6: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(wake_ok));
endmodule

// File: tb/pinbank_gpio_bench.sv
module pinbank_gpio_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [1:0]  bus_size_i = 2'd2;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        bus_rvalid_o;
    logic [31:0] pad_in_i = '0;
    logic [31:0] pad_out_o, pad_oe_o;
    logic [1:0]  irq_o;
    logic        wake_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pinbank_gpio u_pinbank_gpio (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1; bus_addr_i = a; bus_size_i = sz; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd_i = 1; bus_addr_i = a; bus_size_i = sz;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd_i = 0;
    endtask

    task automatic pads(input logic [31:0] v);
        @(negedge clk);
        pad_in_i = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (!rst && bus_rvalid_o) begin
            if (exp_q.size() == 0) chk(bus_rdata_o, 32'hx, "unexpected read");
            else chk(bus_rdata_o, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(8'h00, 2, 32'h18, "R1 revision");
        rd(8'h14, 2, 32'h1, "R1 reset-done");
        rd(8'h30, 2, 32'h2, "R1 cfg2");
        rd(8'h34, 2, 32'hFFFF_FFFF, "R1 dir");
        rd(8'h18, 2, 32'h0, "R1 status0");
        rd(8'h1C, 2, 32'h0, "R1 enable0");
        chk(pad_oe_o, 32'h0, "R1 pad_oe");
        chk({30'd0, irq_o}, 32'h0, "R1 irq");

        // R2 edges into both banks, R4 bank gating
        wr(8'h48, 2, 32'h0000_0008);
        wr(8'h4C, 2, 32'h0000_0020);
        wr(8'h64, 2, 32'h0000_0008);
        pads(32'h0000_0008);
        idle(2);
        rd(8'h18, 2, 32'h08, "R2 rise status0");
        rd(8'h28, 2, 32'h08, "R2 rise status1");
        chk({30'd0, irq_o}, 32'h1, "R4 bank0 only");
        rd(8'h1C, 2, 32'h08, "R5 enable0 via set alias");
        idle(5);
        rd(8'h18, 2, 32'h08, "R10 status held");
        pads(32'h0000_0028);
        pads(32'h0000_0008);
        idle(2);
        rd(8'h28, 2, 32'h28, "R2 fall status1");
        wr(8'h18, 2, 32'h0000_0008);
        idle(1);
        rd(8'h18, 2, 32'h20, "R4 status0 after clear");
        chk({30'd0, irq_o}, 32'h0, "R4 irq after clear");
        wr(8'h74, 2, 32'h0000_0020);
        idle(1);
        chk({30'd0, irq_o}, 32'h2, "R4 bank1 only");

        // R2 output lines ignored, R9 oe
        wr(8'h18, 2, 32'hFFFF_FFFF);
        wr(8'h28, 2, 32'hFFFF_FFFF);
        wr(8'h34, 2, 32'hFFFF_FF7F);
        wr(8'h48, 2, 32'h0000_0088);
        idle(1);
        chk(pad_oe_o, 32'h80, "R9 pad_oe");
        pads(32'h0000_0088);
        idle(2);
        rd(8'h18, 2, 32'h0, "R2 output line no status");

        // R3 level re-assert
        wr(8'h44, 2, 32'h0000_0400);
        pads(32'h0000_0488);
        idle(2);
        rd(8'h28, 2, 32'h400, "R3 level sets");
        wr(8'h18, 2, 32'h0000_0400);
        idle(1);
        rd(8'h18, 2, 32'h400, "R3 level reasserts after clear");
        pads(32'h0000_0088);
        idle(2);
        wr(8'h18, 2, 32'h0000_0400);
        idle(1);
        rd(8'h18, 2, 32'h0, "R3 cleared after level gone");
        wr(8'h44, 2, 32'h0);

        // R8 narrow accesses
        wr(8'h50, 2, 32'h1122_3344);
        wr(8'h52, 0, 32'h0000_00AA);
        rd(8'h50, 2, 32'h11AA_3344, "R8 byte merge");
        wr(8'h50, 1, 32'h0000_BEEF);
        rd(8'h50, 2, 32'h11AA_BEEF, "R8 half merge");
        rd(8'h51, 0, 32'h0011_AABE, "R8 narrow read shift");
        wr(8'h65, 0, 32'h0000_0001);
        rd(8'h1C, 2, 32'h0000_0108, "R8 alias shifted data only");

        // R5 output aliases, R9 pads and read-only
        wr(8'h3C, 2, 32'hF0F0_F0F0);
        wr(8'h90, 2, 32'h0000_00F0);
        wr(8'h94, 2, 32'h0000_000F);
        idle(1);
        chk(pad_out_o, 32'hF0F0_F00F, "R5 output alias pads");
        rd(8'h94, 2, 32'hF0F0_F00F, "R5 alias read");
        wr(8'h00, 2, 32'h0000_00FF);
        wr(8'h38, 2, 32'h1234_5678);
        rd(8'h00, 2, 32'h18, "R9 revision read-only");
        rd(8'h38, 2, 32'h0000_0088, "R9 input data");

        // R6 wakeup
        wr(8'h10, 2, 32'h0000_000C);
        rd(8'h10, 2, 32'h0C, "R7 cfg store");
        wr(8'h84, 2, 32'h0000_0008);
        pads(32'h0000_0080);
        idle(2);
        pads(32'h0000_0088);
        @(negedge clk);
        chk({31'd0, wake_o}, 32'h1, "R6 wake pulse");
        @(negedge clk);
        chk({31'd0, wake_o}, 32'h0, "R6 wake one cycle");
        wr(8'h10, 2, 32'h0000_0004);
        pads(32'h0000_0080);
        idle(2);
        pads(32'h0000_0088);
        @(negedge clk);
        chk({31'd0, wake_o}, 32'h0, "R6 no wake when idle bits zero");

        // R7 soft reset
        wr(8'h10, 2, 32'h0000_001F);
        rd(8'h10, 2, 32'h1D, "R7 cfg masked");
        rd(8'h34, 2, 32'hFFFF_FFFF, "R7 dir reset");
        rd(8'h1C, 2, 32'h0, "R7 enable0 reset");
        rd(8'h50, 2, 32'h0, "R7 spare reset");
        rd(8'h18, 2, 32'h0, "R7 status reset");
        rd(8'h3C, 2, 32'hF0F0_F00F, "R7 output kept");
        wr(8'h30, 2, 32'h0000_00FF);
        rd(8'h30, 2, 32'h7, "R7 cfg2 low bits");

        idle(4);
        if (exp_q.size() != 0) chk(exp_q.size(), 0, "reads outstanding");
        finish_run();
    end
endmodule